// File: doc/BRIEF.md
# SRAM Port Strobe Timing Generator

This block produces the per-cycle control strobes for one port of a synchronous SRAM bank. The active-low select and write inputs are captured on the rising edge of the port clock. The captured select then gates the clock. The block drives a wordline enable during the low half of a selected cycle and an active-low bitline precharge during the high half. It also drives a sense-amplifier enable for reads and a write-driver enable for writes.

A replica bitline input falls when a dummy column has discharged. That input runs through a shift-register delay line clocked by a fast sampling clock. The output of the line is inverted and becomes a "discharged" flag. This flag opens the sense and precharge strobes and closes the write strobe. The port kind is a parameter: read-write, read-only or write-only. It picks which of the sense and write strobes exist and which qualifier feeds them. The depth of the delay line is derived from the port kind and from the number of words per row.

Top module: `sram_port_timing`

## Requirements
- R1: `csN` and `weN` are sampled on the rising edge of `clk`. A cycle whose sampled `csN` was 1 drives no wordline, sense or write strobe, and `prechargeN` stays 1 during it.
- R2: In a selected cycle, `wlEn` is 1 for the whole low half of `clk` and 0 in the high half.
- R3: `prechargeN` is 0 only while `clk` is high in a selected cycle and the discharged flag is set. The flag is still set at the start of a cycle that directly follows a selected cycle, so precharge lasts as long as the delay line takes to see the restored replica.
- R4: `senseEn` is 1 only in the low half of a selected cycle, once the discharged flag is set. On a read-write port it fires only when the sampled `weN` was 1.
- R5: `writeEn` is 1 in the low half of a selected cycle until the discharged flag sets. On a read-write port it fires only when the sampled `weN` was 0.
- R6: The port kind uses the encoding 0 = read-write, 1 = read-only, 2 = write-only. A read-only port never raises `writeEn`. A write-only port never raises `senseEn`. On read-only and write-only ports, `weN` has no effect and chip select alone qualifies the strobe that exists.
- R7: The delay line is 2 fast-clock taps deep, or 8 when words per row is 2 or more, plus 2 more on a read-only port. The discharged flag is the inverse of `replicaBl` as it was that many `fastClk` rising edges earlier.
- R8: `rstN` is an active-low synchronous reset. While it is low, and until the first `clk` edge after it is released, no strobe asserts and `prechargeN` is 1. The delay line resets to the precharged (not discharged) state.
- R9: `senseEn` and `writeEn` are never 1 together. `prechargeN` is never 0 while `wlEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| fastClk | input | 1 | Oversampling clock for the replica delay line |
| rstN | input | 1 | Synchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| weN | input | 1 | Write enable, active low (read-write port only) |
| replicaBl | input | 1 | Replica bitline, 1 = precharged, 0 = discharged |
| clkBuf | output | 1 | Buffered port clock |
| wlEn | output | 1 | Wordline enable |
| prechargeN | output | 1 | Bitline precharge, active low |
| senseEn | output | 1 | Sense-amplifier enable |
| writeEn | output | 1 | Write-driver enable |

## Verification
The bench runs read-write, read-only and write-only ports side by side, each with a model bitline that discharges one fast cycle after its wordline rises. For every cycle it counts how many fast samples each strobe was active and compares those counts with the expected ones. A delay line of the wrong depth shows up as a wrong sense or precharge count. A read-only port left at the read-write depth would show three sense samples instead of one. A swapped qualifier would sense on writes. Back-to-back selected cycles test whether precharge waits for the replica to recover. A wrongly gated precharge would appear in a cycle after an idle one, or overlap the wordline. A deep instance with two words per row must produce no sense pulse within its cycle. Selects asserted during reset check that the capture flops hold in reset.

// File: rtl/sram_port_pkg.sv
`timescale 1ns/1ps
package sram_port_pkg;

  typedef enum logic [1:0] {
    PORT_RW = 2'd0,
    PORT_RO = 2'd1,
    PORT_WO = 2'd2
  } port_kind_e;

  // Registered controls handed from the capture logic to the strobe logic.
  typedef struct packed {
    logic sel;   // port selected this cycle
    logic wrt;   // write requested this cycle (read-write port only)
  } ctl_strobe_t;

  localparam int unsigned BASE_TAPS    = 2;
  localparam int unsigned MUXED_TAPS   = 8;
  localparam int unsigned RO_EXTRA     = 2;

  function automatic int unsigned delayTaps(port_kind_e kind, int unsigned wordsPerRow);
    int unsigned taps;
    taps = (wordsPerRow >= 2) ? MUXED_TAPS : BASE_TAPS;
    if (kind == PORT_RO) taps = taps + RO_EXTRA;
    return taps;
  endfunction

endpackage

// File: rtl/sram_port_ctl_flops.sv
`timescale 1ns/1ps
module sram_port_ctl_flops
  import sram_port_pkg::*;
#(
  parameter port_kind_e KIND = PORT_RW
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        weN,
  output ctl_strobe_t ctl
);

  logic selQ;

  always_ff @(posedge clk) begin
    if (!rstN) selQ <= 1'b0;
    else       selQ <= ~csN;
  end

  generate
    if (KIND == PORT_RW) begin : g_wrt
      logic wrtQ;
      always_ff @(posedge clk) begin
        if (!rstN) wrtQ <= 1'b0;
        else       wrtQ <= ~weN;
      end
      assign ctl.wrt = wrtQ;
    end else begin : g_nowrt
      logic unusedWe;
      assign unusedWe = weN;
      assign ctl.wrt  = 1'b0;
    end
  endgenerate

  assign ctl.sel = selQ;

endmodule

// File: rtl/sram_port_replica_delay.sv
`timescale 1ns/1ps
module sram_port_replica_delay #(
  parameter int unsigned TAPS = 2
) (
  input  logic fastClk,
  input  logic rstN,
  input  logic replicaBl,
  output logic discharged
);

  logic [TAPS-1:0] taps;

  always_ff @(posedge fastClk) begin
    if (!rstN) taps <= '1;                       // precharged state
    else       taps <= {taps[TAPS-2:0], replicaBl};
  end

  assign discharged = ~taps[TAPS-1];             // inverting line

endmodule

// File: rtl/sram_port_strobe_gen.sv
`timescale 1ns/1ps
module sram_port_strobe_gen
  import sram_port_pkg::*;
#(
  parameter port_kind_e KIND = PORT_RW
) (
  input  logic        clkBuf,
  input  ctl_strobe_t ctl,
  input  logic        discharged,
  output logic        wlEn,
  output logic        prechargeN,
  output logic        senseEn,
  output logic        writeEn
);

  logic gatedLow;
  logic gatedHigh;

  assign gatedLow   = ctl.sel & ~clkBuf;
  assign gatedHigh  = ctl.sel &  clkBuf;
  assign wlEn       = gatedLow;
  assign prechargeN = ~(gatedHigh & discharged);

  generate
    if (KIND == PORT_RW) begin : g_rw
      assign senseEn = discharged & gatedLow & ~ctl.wrt;
      assign writeEn = ctl.wrt & ~discharged & gatedLow;
    end else if (KIND == PORT_RO) begin : g_ro
      logic unusedWrt;
      assign unusedWrt = ctl.wrt;
      assign senseEn   = discharged & gatedLow & ctl.sel;
      assign writeEn   = 1'b0;
    end else begin : g_wo
      logic unusedWrt;
      assign unusedWrt = ctl.wrt;
      assign senseEn   = 1'b0;
      assign writeEn   = ctl.sel & ~discharged & gatedLow;
    end
  endgenerate

endmodule

// File: rtl/sram_port_timing.sv
`timescale 1ns/1ps
module sram_port_timing
  import sram_port_pkg::*;
#(
  parameter port_kind_e  PORT_KIND     = PORT_RW,
  parameter int unsigned WORDS_PER_ROW = 1
) (
  input  logic clk,
  input  logic fastClk,
  input  logic rstN,
  input  logic csN,
  input  logic weN,
  input  logic replicaBl,
  output logic clkBuf,
  output logic wlEn,
  output logic prechargeN,
  output logic senseEn,
  output logic writeEn
);

  localparam int unsigned TAPS = delayTaps(PORT_KIND, WORDS_PER_ROW);

  ctl_strobe_t ctl;
  logic        discharged;

  assign clkBuf = clk;

  sram_port_ctl_flops #(.KIND(PORT_KIND)) u_ctl (
    .clk  (clkBuf),
    .rstN (rstN),
    .csN  (csN),
    .weN  (weN),
    .ctl  (ctl)
  );

  sram_port_replica_delay #(.TAPS(TAPS)) u_delay (
    .fastClk    (fastClk),
    .rstN       (rstN),
    .replicaBl  (replicaBl),
    .discharged (discharged)
  );

  sram_port_strobe_gen #(.KIND(PORT_KIND)) u_strobe (
    .clkBuf     (clkBuf),
    .ctl        (ctl),
    .discharged (discharged),
    .wlEn       (wlEn),
    .prechargeN (prechargeN),
    .senseEn    (senseEn),
    .writeEn    (writeEn)
  );

endmodule

// File: rtl/sram_port_timing_chk.sv
`timescale 1ns/1ps
module sram_port_timing_chk
  import sram_port_pkg::*;
#(
  parameter port_kind_e  PORT_KIND     = PORT_RW,
  parameter int unsigned WORDS_PER_ROW = 1
) (
  input logic clk,
  input logic fastClk,
  input logic rstN,
  input logic replicaBl,
  input logic wlEn,
  input logic prechargeN,
  input logic senseEn,
  input logic writeEn
);

  localparam int unsigned TAPS = delayTaps(PORT_KIND, WORDS_PER_ROW);

  // Independent history of the replica input, one entry per fast edge.
  logic [TAPS-1:0] history;
  logic            inRst = 1'b0;

  always_ff @(posedge fastClk) begin
    if (!rstN) history <= '1;
    else       history <= {history[TAPS-2:0], replicaBl};
  end

  always_ff @(posedge clk) inRst <= !rstN;

  AST_SENSE_AFTER_DISCHARGE: assert property (@(posedge fastClk) disable iff (!rstN)
    senseEn |-> !history[TAPS-1]);                                   // R4
  AST_WRITE_BEFORE_DISCHARGE: assert property (@(posedge fastClk) disable iff (!rstN)
    writeEn |-> history[TAPS-1]);                                    // R5
  AST_PRECHARGE_WINDOW: assert property (@(posedge fastClk) disable iff (!rstN)
    !prechargeN |-> (!history[TAPS-1] && clk));                      // R3
  AST_RESET_QUIET: assert property (@(posedge fastClk) disable iff (!rstN)
    inRst |-> (!wlEn && !senseEn && !writeEn && prechargeN));        // R8
  AST_NO_SENSE_WRITE: assert property (@(posedge fastClk) disable iff (!rstN)
    !(senseEn && writeEn));                                          // R9

endmodule

bind sram_port_timing sram_port_timing_chk #(
  .PORT_KIND     (PORT_KIND),
  .WORDS_PER_ROW (WORDS_PER_ROW)
) u_chk (
  .clk        (clk),
  .fastClk    (fastClk),
  .rstN       (rstN),
  .replicaBl  (replicaBl),
  .wlEn       (wlEn),
  .prechargeN (prechargeN),
  .senseEn    (senseEn),
  .writeEn    (writeEn)
);

// File: tb/test_sram_port_timing.sv
`timescale 1ns/1ps
module test_sram_port_timing;
  import sram_port_pkg::*;

  typedef struct packed {
    logic [2:0] wl;
    logic [2:0] pre;
    logic [2:0] sen;
    logic [2:0] wr;
  } cnt_t;

  logic clk = 1'b1;
  logic fastClk = 1'b1;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic weN = 1'b1;
  logic csDeepN = 1'b1;

  always #2.5  clk = ~clk;       // 200 MHz port clock
  always #0.25 fastClk = ~fastClk;

  // index 0 = read-write, 1 = read-only, 2 = write-only, 3 = deep read-write
  logic [3:0] rep = 4'hF;
  logic [3:0] clkB, wl, preN, sen, wr;

  sram_port_timing #(.PORT_KIND(PORT_RW), .WORDS_PER_ROW(1)) i_sram_port_timing (
    .clk(clk), .fastClk(fastClk), .rstN(rstN), .csN(csN), .weN(weN), .replicaBl(rep[0]),
    .clkBuf(clkB[0]), .wlEn(wl[0]), .prechargeN(preN[0]), .senseEn(sen[0]), .writeEn(wr[0]));
  sram_port_timing #(.PORT_KIND(PORT_RO), .WORDS_PER_ROW(1)) i_sram_port_timing_ro (
    .clk(clk), .fastClk(fastClk), .rstN(rstN), .csN(csN), .weN(weN), .replicaBl(rep[1]),
    .clkBuf(clkB[1]), .wlEn(wl[1]), .prechargeN(preN[1]), .senseEn(sen[1]), .writeEn(wr[1]));
  sram_port_timing #(.PORT_KIND(PORT_WO), .WORDS_PER_ROW(1)) i_sram_port_timing_wo (
    .clk(clk), .fastClk(fastClk), .rstN(rstN), .csN(csN), .weN(weN), .replicaBl(rep[2]),
    .clkBuf(clkB[2]), .wlEn(wl[2]), .prechargeN(preN[2]), .senseEn(sen[2]), .writeEn(wr[2]));
  sram_port_timing #(.PORT_KIND(PORT_RW), .WORDS_PER_ROW(2)) i_sram_port_timing_deep (
    .clk(clk), .fastClk(fastClk), .rstN(rstN), .csN(csDeepN), .weN(weN), .replicaBl(rep[3]),
    .clkBuf(clkB[3]), .wlEn(wl[3]), .prechargeN(preN[3]), .senseEn(sen[3]), .writeEn(wr[3]));

  // Model bitlines: discharge one fast cycle after the wordline rises, restore when it falls.
  always @(negedge fastClk) rep <= ~wl;

  int errors = 0;
  int checks = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  cnt_t expQ[3][$];
  logic drvDone = 1'b0;

  // Driver: present one cycle's inputs and push the expected per-port counts.
  bit prevSel = 1'b0;
  task automatic drive(input bit sel, input bit wrt);
    cnt_t e;
    @(negedge clk);
    #0.1;
    csN = !sel;
    weN = !wrt;
    for (int p = 0; p < 3; p++) begin
      e.wl  = sel ? 3'd5 : 3'd0;                                    // R2
      e.pre = (sel && prevSel) ? ((p == 1) ? 3'd4 : 3'd2) : 3'd0;   // R3 R7
      e.sen = 3'd0;
      e.wr  = 3'd0;
      if (sel) begin
        if (p == 0) begin e.sen = wrt ? 3'd0 : 3'd3; e.wr = wrt ? 3'd2 : 3'd0; end // R4 R5
        if (p == 1) e.sen = 3'd1;                                   // R6 R7: weN ignored
        if (p == 2) e.wr  = 3'd2;                                   // R6
      end
      expQ[p].push_back(e);
    end
    prevSel = sel;
  endtask

  // Monitor: count fast samples of each strobe over one port cycle and compare.
  initial begin
    int c[3][4];
    int bad[3];
    cnt_t e;
    wait (rstN);
    @(posedge clk);
    while (!drvDone || expQ[0].size() != 0) begin
      for (int p = 0; p < 3; p++) begin
        bad[p] = 0;
        for (int f = 0; f < 4; f++) c[p][f] = 0;
      end
      for (int s = 0; s < 10; s++) begin
        @(negedge fastClk);
        for (int p = 0; p < 3; p++) begin
          c[p][0] += wl[p];
          c[p][1] += !preN[p];
          c[p][2] += sen[p];
          c[p][3] += wr[p];
          if ((sen[p] && wr[p]) || (!preN[p] && wl[p])) bad[p]++;
        end
      end
      for (int p = 0; p < 3; p++) begin
        e = expQ[p].pop_front();
        check($sformatf("R2 R1 wordline port%0d", p), c[p][0], e.wl);
        check($sformatf("R3 precharge port%0d", p), c[p][1], e.pre);
        check($sformatf("R4 R7 sense port%0d", p), c[p][2], e.sen);
        check($sformatf("R5 R6 write port%0d", p), c[p][3], e.wr);
        check($sformatf("R9 overlap port%0d", p), bad[p], 0);
      end
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finishRun();
  end

  initial begin
    int q;
    // R8: select asserted during reset must not reach the strobes.
    csN = 1'b0;
    csDeepN = 1'b0;
    repeat (4) @(posedge clk);
    q = 0;
    for (int s = 0; s < 10; s++) begin
      @(negedge fastClk);
      for (int p = 0; p < 4; p++) q += wl[p] + sen[p] + wr[p] + !preN[p];
    end
    check("R8 reset quiet", q, 0);
    check("R8 clkBuf follows clk", clkB[0], clk);
    @(negedge clk);
    #0.1;
    csDeepN = 1'b1;
    rstN = 1'b1;
    csN = 1'b1;
    weN = 1'b1;
    // first window after reset: idle
    for (int p = 0; p < 3; p++) expQ[p].push_back('0);       // R1
    prevSel = 1'b0;
    for (int i = 0; i < 30; i++) drive((i % 5) != 3, (i % 3) == 1);
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b1);   // write after idle: no precharge
    drive(1'b1, 1'b0);   // read after write: precharge
    drive(1'b0, 1'b1);   // R1: weN alone does nothing
    drive(1'b0, 1'b0);
    drvDone = 1'b1;
    wait (expQ[0].size() == 0);
    repeat (2) @(posedge clk);

    // R7: deep line (8 taps) - an isolated read senses nothing within its cycle.
    begin
      int dw, ds, dp, dr;
      @(negedge clk);
      #0.1;
      csDeepN = 1'b0;
      weN = 1'b1;
      @(posedge clk);
      dw = 0; ds = 0; dp = 0; dr = 0;
      fork
        begin
          @(negedge clk);
          #0.1;
          csDeepN = 1'b1;
        end
        for (int s = 0; s < 10; s++) begin
          @(negedge fastClk);
          dw += wl[3]; ds += sen[3]; dp += !preN[3]; dr += wr[3];
        end
      join
      check("R7 deep wordline", dw, 5);
      check("R7 deep sense", ds, 0);
      check("R7 deep precharge", dp, 0);
      check("R4 deep no write on read", dr, 0);
    end
    repeat (2) @(posedge clk);
    finishRun();
  end

endmodule